// File: doc/BRIEF.md
# Out-of-Order Instruction Window

This block sits between instruction decode and the execution units. Decode pushes up to two decoded instructions per cycle into free slots; the second lane of a pair is always the younger of the two. Each cycle, for every functional unit that reports itself available, the window picks one waiting instruction for that unit and presents it on that unit's issue port. Instructions leave in whatever order their hazards clear, not in program order.

An instruction is held back while any of three hazards against older instructions in the window remains:
- **Read-after-write:** an older writer of one of its sources has not yet completed.
- **Write-after-write:** an older writer of its own destination has not yet completed.
- **Write-after-read:** an older reader of its destination has not yet issued. Operands are taken at issue, so the read is done once the reader has issued.

Issued instructions stay in the window until the execution side broadcasts completion of their destination register. The completion broadcast frees the entry and releases every instruction that was waiting on it.

Decode is told to stop through a full flag that rises while fewer than two slots are free, so that a full pair can always be taken when the flag is low. Register renaming, operand values and branch recovery are not part of the block.

Top module: `ooo_window`

## Requirements
- R1: After reset the window is empty: `full` is low, and no `iss_valid` bit is set even with every unit available.
- R2: Each accepted instruction becomes eligible for issue in the cycle after it is inserted, and up to two are taken per cycle. Lane 0 occupies bits [UW-1:0] or [RW-1:0] of each lane bus, lane 1 the next field up, and lane 1 counts as younger than lane 0.
- R3: For each unit, at most one instruction is issued per cycle, and only while that unit's `fu_avail` bit is high. The issue port carries the destination register and both source register numbers of the chosen instruction.
- R4: When several issuable instructions target the same unit, the one inserted earliest is issued first, whatever slot it occupies.
- R5: An instruction whose used source equals the destination of an older instruction still in the window does not issue until that older instruction has completed. This includes the older partner of the same insert pair.
- R6: An instruction whose destination equals the destination of an older instruction still in the window does not issue until that older instruction has completed.
- R7: An instruction whose destination equals a used source of an older, not yet issued instruction does not issue until that older instruction has issued.
- R8: A younger instruction with no hazard issues ahead of an older instruction that is stalled on a hazard.
- R9: A completion broadcast frees the issued instruction whose destination matches, and instructions waiting on it may issue in the following cycle. A broadcast that matches no issued instruction changes nothing: unissued instructions with that destination stay, and waiting instructions stay blocked.
- R10: `full` is high while fewer than two slots are free. Instructions offered while `full` is high are dropped and never issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 2 | Per-lane insert request |
| ins_unit | input | 2*UW | Per-lane target functional unit number |
| ins_dst | input | 2*RW | Per-lane destination register |
| ins_src_a | input | 2*RW | Per-lane first source register |
| ins_src_b | input | 2*RW | Per-lane second source register |
| ins_use_a | input | 2 | Per-lane: first source is read |
| ins_use_b | input | 2 | Per-lane: second source is read |
| full | output | 1 | Fewer than two free slots; inserts are refused |
| fu_avail | input | UNITS | Per-unit: unit can accept an instruction this cycle |
| iss_valid | output | UNITS | Per-unit: an instruction is issued this cycle |
| iss_dst | output | UNITS*RW | Per-unit destination of the issued instruction |
| iss_src_a | output | UNITS*RW | Per-unit first source of the issued instruction |
| iss_src_b | output | UNITS*RW | Per-unit second source of the issued instruction |
| cmp_valid | input | 1 | Completion broadcast valid |
| cmp_reg | input | RW | Destination register that finished |

## Verification
Assertions check the following on every cycle, using comparators that are independent of the stored wait vectors:
- No issue happens on an unavailable unit.
- At most one instruction is chosen per unit.
- No issued instruction has a read-after-write, write-after-write or write-after-read conflict with an older entry still in the window.
- A completion broadcast never matches two in-flight entries.
- The occupancy never grows while `full` is high.

Only the directed scenarios can show the behaviours that involve order or loss:
- the oldest-first choice across reused slots;
- a younger instruction overtaking a stalled one;
- wakeup exactly one cycle after completion;
- unmatched broadcasts being ignored;
- instructions offered while full never reappearing on any issue port.

// File: rtl/ooo_window_pkg.sv
package ooo_window_pkg;
  localparam int unsigned DEF_ENTRIES = 8;
  localparam int unsigned DEF_UNITS   = 3;
  localparam int unsigned DEF_REGS    = 32;
  localparam int unsigned LANES       = 2;

  // width of an index into n items, at least one bit
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ooo_window_alloc.sv
module ooo_window_alloc
  import ooo_window_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  localparam int unsigned CW = $clog2(ENTRIES + 1)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] vld,
  input  logic [LANES-1:0]   req,
  output logic               full,
  output logic [ENTRIES-1:0] slot_oh [LANES]
);

  logic [ENTRIES-1:0] free_v, first_v, rest_v, second_v;
  logic [CW-1:0]      free_cnt;
  logic               acc0, acc1;

  always_comb begin
    free_v   = ~vld;
    free_cnt = '0;
    for (int i = 0; i < int'(ENTRIES); i++) begin
      free_cnt = free_cnt + CW'(free_v[i]);
    end
    full     = (free_cnt < CW'(2));
    first_v  = free_v & (~free_v + 1'b1);
    rest_v   = free_v & ~first_v;
    second_v = rest_v & (~rest_v + 1'b1);
    acc0     = req[0] & ~full;
    acc1     = req[1] & ~full;
    slot_oh[0] = acc0 ? first_v : '0;
    slot_oh[1] = acc1 ? (acc0 ? second_v : first_v) : '0;
  end

  // R10
  full_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> ($countones(vld) <= $past($countones(vld))));

endmodule

// File: rtl/ooo_window_depgen.sv
module ooo_window_depgen
  import ooo_window_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned RW      = 5
)(
  input  logic [ENTRIES-1:0] keep_vld,
  input  logic [ENTRIES-1:0] pend_iss,
  input  logic [RW-1:0]      ent_dst [ENTRIES],
  input  logic [RW-1:0]      ent_sa  [ENTRIES],
  input  logic [RW-1:0]      ent_sb  [ENTRIES],
  input  logic [ENTRIES-1:0] ent_ua,
  input  logic [ENTRIES-1:0] ent_ub,
  input  logic [RW-1:0]      new_dst,
  input  logic [RW-1:0]      new_sa,
  input  logic [RW-1:0]      new_sb,
  input  logic               new_ua,
  input  logic               new_ub,
  input  logic               prior_en,
  input  logic [ENTRIES-1:0] prior_oh,
  input  logic [RW-1:0]      prior_dst,
  input  logic [RW-1:0]      prior_sa,
  input  logic [RW-1:0]      prior_sb,
  input  logic               prior_ua,
  input  logic               prior_ub,
  output logic [ENTRIES-1:0] wait_done,
  output logic [ENTRIES-1:0] wait_iss
);

  logic raw_p, waw_p, war_p;

  always_comb begin
    for (int j = 0; j < int'(ENTRIES); j++) begin
      wait_done[j] = keep_vld[j] &
                     ((new_ua && (new_sa == ent_dst[j])) ||
                      (new_ub && (new_sb == ent_dst[j])) ||
                      (new_dst == ent_dst[j]));
      wait_iss[j]  = pend_iss[j] &
                     ((ent_ua[j] && (ent_sa[j] == new_dst)) ||
                      (ent_ub[j] && (ent_sb[j] == new_dst)));
    end
    raw_p = (new_ua && (new_sa == prior_dst)) || (new_ub && (new_sb == prior_dst));
    waw_p = (new_dst == prior_dst);
    war_p = (prior_ua && (prior_sa == new_dst)) || (prior_ub && (prior_sb == new_dst));
    if (prior_en && (raw_p || waw_p)) wait_done = wait_done | prior_oh;
    if (prior_en && war_p)            wait_iss  = wait_iss | prior_oh;
  end

endmodule

// File: rtl/ooo_window_pick.sv
module ooo_window_pick
  import ooo_window_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] cand,
  input  logic [ENTRIES-1:0] older [ENTRIES],
  input  logic               avail,
  output logic [ENTRIES-1:0] sel_oh,
  output logic               sel_any
);

  always_comb begin
    for (int i = 0; i < int'(ENTRIES); i++) begin
      sel_oh[i] = avail & cand[i] & ~(|(older[i] & cand));
    end
    sel_any = |sel_oh;
  end

  // R3
  issue_needs_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_any |-> avail);

  // R3
  one_pick_per_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh));

endmodule

// File: rtl/ooo_window.sv
module ooo_window
  import ooo_window_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned UNITS   = DEF_UNITS,
  parameter int unsigned NREGS   = DEF_REGS,
  localparam int unsigned RW = idx_w(NREGS),
  localparam int unsigned UW = idx_w(UNITS)
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      ins_valid,
  input  logic [LANES*UW-1:0]   ins_unit,
  input  logic [LANES*RW-1:0]   ins_dst,
  input  logic [LANES*RW-1:0]   ins_src_a,
  input  logic [LANES*RW-1:0]   ins_src_b,
  input  logic [LANES-1:0]      ins_use_a,
  input  logic [LANES-1:0]      ins_use_b,
  output logic                  full,
  input  logic [UNITS-1:0]      fu_avail,
  output logic [UNITS-1:0]      iss_valid,
  output logic [UNITS*RW-1:0]   iss_dst,
  output logic [UNITS*RW-1:0]   iss_src_a,
  output logic [UNITS*RW-1:0]   iss_src_b,
  input  logic                  cmp_valid,
  input  logic [RW-1:0]         cmp_reg
);

  // entry state
  logic [ENTRIES-1:0] vld_q, vld_d, isd_q, isd_d;
  logic [ENTRIES-1:0] older_q [ENTRIES];
  logic [ENTRIES-1:0] older_d [ENTRIES];
  logic [ENTRIES-1:0] wdone_q [ENTRIES];
  logic [ENTRIES-1:0] wdone_d [ENTRIES];
  logic [ENTRIES-1:0] wiss_q  [ENTRIES];
  logic [ENTRIES-1:0] wiss_d  [ENTRIES];
  logic [UW-1:0]      unit_q  [ENTRIES];
  logic [RW-1:0]      dst_q   [ENTRIES];
  logic [RW-1:0]      sa_q    [ENTRIES];
  logic [RW-1:0]      sb_q    [ENTRIES];
  logic [ENTRIES-1:0] ua_q, ub_q;

  // lane decode
  logic [UW-1:0] ln_unit [LANES];
  logic [RW-1:0] ln_dst  [LANES];
  logic [RW-1:0] ln_sa   [LANES];
  logic [RW-1:0] ln_sb   [LANES];

  always_comb begin
    for (int k = 0; k < int'(LANES); k++) begin
      ln_unit[k] = ins_unit[k*UW +: UW];
      ln_dst[k]  = ins_dst[k*RW +: RW];
      ln_sa[k]   = ins_src_a[k*RW +: RW];
      ln_sb[k]   = ins_src_b[k*RW +: RW];
    end
  end

  // slot allocation
  logic [ENTRIES-1:0] slot_oh [LANES];

  ooo_window_alloc #(.ENTRIES(ENTRIES)) alloc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld     (vld_q),
    .req     (ins_valid),
    .full    (full),
    .slot_oh (slot_oh)
  );

  // completion match
  logic [ENTRIES-1:0] cmp_hit;

  always_comb begin
    for (int e = 0; e < int'(ENTRIES); e++) begin
      cmp_hit[e] = cmp_valid & vld_q[e] & isd_q[e] & (dst_q[e] == cmp_reg);
    end
  end

  // readiness and per-unit candidates
  logic [ENTRIES-1:0] ready;
  logic [ENTRIES-1:0] cand [UNITS];
  logic [ENTRIES-1:0] sel  [UNITS];
  logic [ENTRIES-1:0] issue_vec;

  always_comb begin
    for (int e = 0; e < int'(ENTRIES); e++) begin
      ready[e] = vld_q[e] & ~isd_q[e] & ~(|wdone_q[e]) & ~(|wiss_q[e]);
    end
    for (int f = 0; f < int'(UNITS); f++) begin
      for (int e = 0; e < int'(ENTRIES); e++) begin
        cand[f][e] = ready[e] & (unit_q[e] == UW'(f));
      end
    end
  end

  for (genvar f = 0; f < int'(UNITS); f++) begin : g_pick
    ooo_window_pick #(.ENTRIES(ENTRIES)) pick_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cand    (cand[f]),
      .older   (older_q),
      .avail   (fu_avail[f]),
      .sel_oh  (sel[f]),
      .sel_any (iss_valid[f])
    );
  end

  // issue payload
  always_comb begin
    issue_vec = '0;
    iss_dst   = '0;
    iss_src_a = '0;
    iss_src_b = '0;
    for (int f = 0; f < int'(UNITS); f++) begin
      issue_vec = issue_vec | sel[f];
      for (int e = 0; e < int'(ENTRIES); e++) begin
        if (sel[f][e]) begin
          iss_dst[f*RW +: RW]   = iss_dst[f*RW +: RW]   | dst_q[e];
          iss_src_a[f*RW +: RW] = iss_src_a[f*RW +: RW] | sa_q[e];
          iss_src_b[f*RW +: RW] = iss_src_b[f*RW +: RW] | sb_q[e];
        end
      end
    end
  end

  // dependency vectors for arriving instructions
  logic [ENTRIES-1:0] keep_vld, pend_iss;
  logic [ENTRIES-1:0] new_older [LANES];
  logic [ENTRIES-1:0] dg_done   [LANES];
  logic [ENTRIES-1:0] dg_iss    [LANES];

  assign keep_vld     = vld_q & ~cmp_hit;
  assign pend_iss     = vld_q & ~isd_q & ~issue_vec;
  assign new_older[0] = keep_vld;
  assign new_older[1] = keep_vld | slot_oh[0];

  for (genvar k = 0; k < int'(LANES); k++) begin : g_dep
    if (k == 0) begin : g_first
      ooo_window_depgen #(.ENTRIES(ENTRIES), .RW(RW)) dep_i (
        .keep_vld (keep_vld), .pend_iss (pend_iss),
        .ent_dst (dst_q), .ent_sa (sa_q), .ent_sb (sb_q),
        .ent_ua (ua_q), .ent_ub (ub_q),
        .new_dst (ln_dst[k]), .new_sa (ln_sa[k]), .new_sb (ln_sb[k]),
        .new_ua (ins_use_a[k]), .new_ub (ins_use_b[k]),
        .prior_en (1'b0), .prior_oh ('0),
        .prior_dst ('0), .prior_sa ('0), .prior_sb ('0),
        .prior_ua (1'b0), .prior_ub (1'b0),
        .wait_done (dg_done[k]), .wait_iss (dg_iss[k])
      );
    end else begin : g_next
      ooo_window_depgen #(.ENTRIES(ENTRIES), .RW(RW)) dep_i (
        .keep_vld (keep_vld), .pend_iss (pend_iss),
        .ent_dst (dst_q), .ent_sa (sa_q), .ent_sb (sb_q),
        .ent_ua (ua_q), .ent_ub (ub_q),
        .new_dst (ln_dst[k]), .new_sa (ln_sa[k]), .new_sb (ln_sb[k]),
        .new_ua (ins_use_a[k]), .new_ub (ins_use_b[k]),
        .prior_en (|slot_oh[k-1]), .prior_oh (slot_oh[k-1]),
        .prior_dst (ln_dst[k-1]), .prior_sa (ln_sa[k-1]), .prior_sb (ln_sb[k-1]),
        .prior_ua (ins_use_a[k-1]), .prior_ub (ins_use_b[k-1]),
        .wait_done (dg_done[k]), .wait_iss (dg_iss[k])
      );
    end
  end

  // next state
  logic [ENTRIES-1:0] wr_en;

  always_comb begin
    wr_en = slot_oh[0] | slot_oh[1];
    vld_d = keep_vld | wr_en;
    isd_d = (isd_q | issue_vec) & ~cmp_hit & ~wr_en;
    for (int e = 0; e < int'(ENTRIES); e++) begin
      older_d[e] = older_q[e] & ~cmp_hit;
      wdone_d[e] = wdone_q[e] & ~cmp_hit;
      wiss_d[e]  = wiss_q[e] & ~issue_vec & ~cmp_hit;
      for (int k = 0; k < int'(LANES); k++) begin
        if (slot_oh[k][e]) begin
          older_d[e] = new_older[k];
          wdone_d[e] = dg_done[k];
          wiss_d[e]  = dg_iss[k];
        end
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      isd_q <= '0;
      for (int e = 0; e < int'(ENTRIES); e++) begin
        older_q[e] <= '0;
        wdone_q[e] <= '0;
        wiss_q[e]  <= '0;
      end
    end else begin
      vld_q <= vld_d;
      isd_q <= isd_d;
      for (int e = 0; e < int'(ENTRIES); e++) begin
        older_q[e] <= older_d[e];
        wdone_q[e] <= wdone_d[e];
        wiss_q[e]  <= wiss_d[e];
      end
    end
  end

  // payload registers, loaded only on insert
  always_ff @(posedge clk) begin
    for (int e = 0; e < int'(ENTRIES); e++) begin
      if (wr_en[e]) begin
        if (slot_oh[1][e]) begin
          unit_q[e] <= ln_unit[1];
          dst_q[e]  <= ln_dst[1];
          sa_q[e]   <= ln_sa[1];
          sb_q[e]   <= ln_sb[1];
          ua_q[e]   <= ins_use_a[1];
          ub_q[e]   <= ins_use_b[1];
        end else begin
          unit_q[e] <= ln_unit[0];
          dst_q[e]  <= ln_dst[0];
          sa_q[e]   <= ln_sa[0];
          sb_q[e]   <= ln_sb[0];
          ua_q[e]   <= ins_use_a[0];
          ub_q[e]   <= ins_use_b[0];
        end
      end
    end
  end

  // hazard monitors built from direct register comparisons
  logic [UNITS-1:0] raw_bad, waw_bad, war_bad;

  always_comb begin
    raw_bad = '0;
    waw_bad = '0;
    war_bad = '0;
    for (int f = 0; f < int'(UNITS); f++) begin
      for (int e = 0; e < int'(ENTRIES); e++) begin
        for (int j = 0; j < int'(ENTRIES); j++) begin
          if (sel[f][e] && older_q[e][j] && vld_q[j]) begin
            if ((ua_q[e] && (sa_q[e] == dst_q[j])) || (ub_q[e] && (sb_q[e] == dst_q[j])))
              raw_bad[f] = 1'b1;
            if (dst_q[e] == dst_q[j])
              waw_bad[f] = 1'b1;
            if (!isd_q[j] && ((ua_q[j] && (sa_q[j] == dst_q[e])) ||
                              (ub_q[j] && (sb_q[j] == dst_q[e]))))
              war_bad[f] = 1'b1;
          end
        end
      end
    end
  end

  // R5
  no_raw_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_bad == '0);

  // R6
  no_waw_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waw_bad == '0);

  // R7
  no_war_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    war_bad == '0);

  // R6
  single_writer_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmp_hit));

endmodule

// File: tb/ooo_window_tb_top.sv
module ooo_window_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;
  localparam int UW = 2;
  localparam int UNITS = 3;

  logic              clk;
  logic              rst_n;
  logic [1:0]        ins_valid;
  logic [2*UW-1:0]   ins_unit;
  logic [2*RW-1:0]   ins_dst, ins_src_a, ins_src_b;
  logic [1:0]        ins_use_a, ins_use_b;
  logic              full;
  logic [UNITS-1:0]  fu_avail, iss_valid;
  logic [UNITS*RW-1:0] iss_dst, iss_src_a, iss_src_b;
  logic              cmp_valid;
  logic [RW-1:0]     cmp_reg;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_cnt = 0;

  ooo_window dut_i (
    .clk (clk), .rst_n (rst_n),
    .ins_valid (ins_valid), .ins_unit (ins_unit), .ins_dst (ins_dst),
    .ins_src_a (ins_src_a), .ins_src_b (ins_src_b),
    .ins_use_a (ins_use_a), .ins_use_b (ins_use_b),
    .full (full), .fu_avail (fu_avail), .iss_valid (iss_valid),
    .iss_dst (iss_dst), .iss_src_a (iss_src_a), .iss_src_b (iss_src_b),
    .cmp_valid (cmp_valid), .cmp_reg (cmp_reg)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 5000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=5000", cyc_cnt);
      summary();
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic lane(input int k, input int fu, input int d,
                      input int sa, input int ua, input int sb, input int ub);
    ins_valid[k] = 1'b1;
    ins_unit[k*UW +: UW] = UW'(fu);
    ins_dst[k*RW +: RW] = RW'(d);
    ins_src_a[k*RW +: RW] = RW'(sa);
    ins_src_b[k*RW +: RW] = RW'(sb);
    ins_use_a[k] = ua[0];
    ins_use_b[k] = ub[0];
  endtask

  task automatic no_ins();
    ins_valid = '0;
  endtask

  task automatic complete(input int r);
    cmp_valid = 1'b1;
    cmp_reg = RW'(r);
    cyc();
    cmp_valid = 1'b0;
  endtask

  function automatic int dst_of(input int f);
    return int'(iss_dst[f*RW +: RW]);
  endfunction

  task automatic t_reset();
    fu_avail = '1;
    settle();
    check("R1 full after reset", int'(full), 0);
    check("R1 no issue after reset", int'(iss_valid), 0);
  endtask

  task automatic t_pair_issue();
    fu_avail = '1;
    lane(0, 0, 1, 0, 0, 0, 0);
    lane(1, 1, 2, 0, 0, 0, 0);
    cyc(); no_ins(); settle();
    check("R2 lane0 issues next cycle", int'(iss_valid[0]), 1);
    check("R2 lane0 dest", dst_of(0), 1);
    check("R2 lane1 issues next cycle", int'(iss_valid[1]), 1);
    check("R3 lane1 dest on its unit", dst_of(1), 2);
    cyc(); settle();
    check("R3 nothing left to issue", int'(iss_valid), 0);
    complete(1); complete(2);
  endtask

  task automatic t_oldest();
    fu_avail = 3'b010;
    lane(0, 1, 3, 0, 0, 0, 0);
    lane(1, 0, 4, 0, 0, 0, 0);
    cyc(); no_ins(); settle();
    check("R3 unavailable unit idle", int'(iss_valid[0]), 0);
    check("R3 available unit dest", dst_of(1), 3);
    cyc();
    complete(3);
    lane(0, 0, 5, 0, 0, 0, 0);
    cyc(); no_ins();
    fu_avail = '1; settle();
    check("R4 oldest first", dst_of(0), 4);
    cyc(); settle();
    check("R4 younger second valid", int'(iss_valid[0]), 1);
    check("R4 younger second dest", dst_of(0), 5);
    cyc(); settle();
    check("R4 queue drained", int'(iss_valid[0]), 0);
    complete(4); complete(5);
  endtask

  task automatic t_raw_bypass();
    fu_avail = '1;
    lane(0, 0, 6, 1, 1, 0, 0);
    lane(1, 1, 7, 6, 1, 0, 0);
    cyc(); no_ins();
    lane(0, 1, 8, 2, 1, 0, 0);
    settle();
    check("R5 producer issues", dst_of(0), 6);
    check("R5 same-pair consumer held", int'(iss_valid[1]), 0);
    cyc(); no_ins(); settle();
    check("R8 younger bypass valid", int'(iss_valid[1]), 1);
    check("R8 younger bypass dest", dst_of(1), 8);
    cyc(); settle();
    check("R5 consumer held while producer in flight", int'(iss_valid[1]), 0);
    complete(9); settle();
    check("R9 unmatched broadcast ignored", int'(iss_valid[1]), 0);
    complete(7); settle();
    check("R9 broadcast of unissued dest ignored", int'(iss_valid[1]), 0);
    complete(6); settle();
    check("R9 wakeup after completion", int'(iss_valid[1]), 1);
    check("R9 woken dest", dst_of(1), 7);
    check("R3 woken source a", int'(iss_src_a[RW +: RW]), 6);
    cyc();
    complete(7); complete(8);
  endtask

  task automatic t_waw();
    fu_avail = '1;
    lane(0, 0, 10, 0, 0, 0, 0);
    lane(1, 1, 10, 0, 0, 0, 0);
    cyc(); no_ins(); settle();
    check("R6 first writer issues", dst_of(0), 10);
    check("R6 second writer held", int'(iss_valid[1]), 0);
    cyc(); settle();
    check("R6 second writer held in flight", int'(iss_valid[1]), 0);
    complete(10); settle();
    check("R6 second writer released", int'(iss_valid[1]), 1);
    cyc();
    complete(10);
  endtask

  task automatic t_war();
    fu_avail = 3'b110;
    lane(0, 0, 11, 0, 0, 12, 1);
    lane(1, 1, 12, 0, 0, 0, 0);
    cyc(); no_ins(); settle();
    check("R7 overwriter held", int'(iss_valid[1]), 0);
    check("R3 blocked unit idle", int'(iss_valid[0]), 0);
    cyc(); settle();
    check("R7 overwriter still held", int'(iss_valid[1]), 0);
    fu_avail = '1; settle();
    check("R7 reader issues", dst_of(0), 11);
    check("R7 overwriter held same cycle", int'(iss_valid[1]), 0);
    cyc(); settle();
    check("R7 overwriter released", int'(iss_valid[1]), 1);
    check("R7 overwriter dest", dst_of(1), 12);
    cyc();
    complete(11); complete(12);
  endtask

  task automatic t_full();
    int q[$];
    int seen = 0;
    int bad = 0;
    fu_avail = '0; settle();
    check("R10 empty not full", int'(full), 0);
    for (int p = 0; p < 4; p++) begin
      lane(0, 0, 16 + 2*p, 0, 0, 0, 0);
      lane(1, 1, 17 + 2*p, 0, 0, 0, 0);
      cyc(); no_ins(); settle();
      check("R10 full flag", int'(full), (p == 3) ? 1 : 0);
    end
    lane(0, 0, 24, 0, 0, 0, 0);
    lane(1, 1, 25, 0, 0, 0, 0);
    cyc(); no_ins(); settle();
    check("R10 still full", int'(full), 1);
    fu_avail = '1;
    for (int it = 0; it < 24; it++) begin
      if (q.size() > 0) begin
        cmp_valid = 1'b1;
        cmp_reg = RW'(q.pop_front());
      end
      settle();
      for (int f = 0; f < UNITS; f++) begin
        if (iss_valid[f]) begin
          seen++;
          if (dst_of(f) >= 24) bad++;
          q.push_back(dst_of(f));
        end
      end
      cyc();
      cmp_valid = 1'b0;
    end
    check("R10 accepted count issued", seen, 8);
    check("R10 dropped never issue", bad, 0);
    settle();
    check("R10 not full after drain", int'(full), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    ins_valid = '0; ins_unit = '0; ins_dst = '0;
    ins_src_a = '0; ins_src_b = '0; ins_use_a = '0; ins_use_b = '0;
    fu_avail = '0; cmp_valid = 1'b0; cmp_reg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pair_issue();
    t_oldest();
    t_raw_bypass();
    t_waw();
    t_war();
    t_full();
    summary();
  end
endmodule